// File: doc/BRIEF.md
# Programmable Frequency Divider Output Stage

This block turns the overflow strobes of a set of timers into a pair of square-wave pins. One timer is chosen by a source-select input, and its overflow strobe is the only thing that advances the divider. Each selected strobe flips an internal toggle bit. The output frequency is therefore half the overflow rate of the chosen timer. The timer's preload value sets the division ratio.

The two pins are complementary while the function is active, so a piezo buzzer can be driven across both pins. A function-enable input and an output-data input act as gates. If either one is low, both pins are held low. The toggle bit keeps running underneath, so when the gates open again the pins resume from the current toggle phase.

All inputs belong to the system clock domain. Overflow strobes are one-cycle pulses. A strobe that stays high for several cycles counts as one overflow per cycle.

Top module: `pfd_out`

## Requirements
- R1: A synchronous active-low reset clears the toggle bit to 0. After reset, with both gates high, `pfd_p` is 0 and `pfd_n` is 1.
- R2: With `src_sel` = 0, only `ovf[0]` advances the divider, and `ovf[1]` has no effect on the pins.
- R3: With `src_sel` = 1, only `ovf[1]` advances the divider, and `ovf[0]` has no effect on the pins.
- R4: Each clock edge at which the selected overflow strobe is high flips the toggle bit. The pins show the new value in the cycle after the strobe.
- R5: While `fn_en` = 1 and `dat` = 1, `pfd_p` equals the toggle bit and `pfd_n` equals its inverse.
- R6: While `fn_en` = 0, both pins are 0. The toggle bit keeps following the selected strobes.
- R7: While `dat` = 0, both pins are 0. The toggle bit keeps following the selected strobes. When `dat` returns to 1, the pins show the current toggle phase in that same cycle.
- R8: Changing `src_sel` does not clear or flip the toggle bit.
- R9: A selected strobe held high for k consecutive cycles flips the toggle bit k times. In a cycle with no selected strobe, the toggle bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ovf | input | N_SRC | One overflow strobe per timer |
| src_sel | input | SEL_W | Index of the timer whose overflow drives the divider |
| fn_en | input | 1 | Divider function enable; 0 forces both pins low |
| dat | input | 1 | Output data gate; 0 forces both pins low |
| pfd_p | output | 1 | Divider output, true phase |
| pfd_n | output | 1 | Divider output, inverted phase |

## Verification
The toggle bit is the only register. A selected strobe sampled at a rising edge shows on the pins one cycle later. The gates reach the pins combinationally, in the same cycle they change.

The bench drives all inputs just after each falling edge. It advances a behavioural toggle model at each rising edge from the inputs it drove. At the next falling edge, before the inputs change, it compares both pins with the gated model. Every cycle therefore checks both the one-cycle latency of the toggle and the zero-cycle latency of the gates.

// File: rtl/pfd_pkg.sv
// Package: shared types for the frequency divider output stage.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package pfd_pkg;

    // Gate controls that decide whether the toggle phase reaches the pins.
    typedef struct packed {
        logic fn_en;   // divider function selected
        logic dat;     // output data bit (on/off)
    } pfd_gate_t;

    // Pin pair driven by the output stage.
    typedef struct packed {
        logic p;       // true phase
        logic n;       // inverted phase
    } pfd_pins_t;

endpackage

// File: rtl/pfd_src_mux.sv
// Module: pfd_src_mux
// Picks the overflow strobe of the timer indexed by sel.
// Assumes: the strobes are single-cycle pulses in the clk domain.
// An index outside 0..N_SRC-1 selects no strobe.
module pfd_src_mux #(
    parameter int N_SRC = 2,
    parameter int SEL_W = 1
) (
    input  logic [N_SRC-1:0] ovf,
    input  logic [SEL_W-1:0] sel,
    output logic             strobe
);

    logic [N_SRC-1:0] hit;

    // One match term per timer source.
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = ovf[i] & (sel == SEL_W'(i));
    end

    // At most one term can be set, so an OR reduction forms the strobe.
    assign strobe = |hit;

endmodule

// File: rtl/pfd_toggle.sv
// Module: pfd_toggle
// Flips a single phase bit on every clock edge at which strobe is high.
// Assumes: synchronous active-low reset, strobe synchronous to clk.
module pfd_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic tgl
);

    // Phase register: cleared by reset, inverted by each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tgl <= 1'b0;
        else if (strobe)
            tgl <= ~tgl;
    end

    // R4: a strobe flips the phase on the next edge.
    p_strobe_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (tgl != $past(tgl)));

    // R9: without a strobe the phase holds.
    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(tgl));

endmodule

// File: rtl/pfd_pin_gate.sv
// Module: pfd_pin_gate
// Drives the complementary pin pair from the phase bit, or forces both
// pins low when either gate control is low.
// Assumes: gates are stable for the cycle; the output is combinational,
// so opening the gate shows the current phase without an extra edge.
module pfd_pin_gate
    import pfd_pkg::*;
(
    input  logic      tgl,
    input  pfd_gate_t gate,
    output pfd_pins_t pins
);

    logic open_g;

    // Both controls must be high for the phase to reach the pins.
    always_comb begin
        open_g = gate.fn_en & gate.dat;
        pins.p = open_g &  tgl;
        pins.n = open_g & ~tgl;
    end

endmodule

// File: rtl/pfd_out.sv
// Module: pfd_out (top)
// Programmable frequency divider output stage. It selects one timer's
// overflow strobe, toggles a phase bit on each one, and drives a gated
// complementary pin pair.
// Assumes: all inputs are synchronous to clk; synchronous active-low reset.
module pfd_out
    import pfd_pkg::*;
#(
    parameter  int N_SRC = 2,
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] ovf,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             fn_en,
    input  logic             dat,
    output logic             pfd_p,
    output logic             pfd_n
);

    logic      sel_strobe;
    logic      phase;
    pfd_gate_t gate;
    pfd_pins_t pins;

    // Bundle the gate controls for the pin stage.
    always_comb begin
        gate.fn_en = fn_en;
        gate.dat   = dat;
    end

    pfd_src_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux (
        .ovf    (ovf),
        .sel    (src_sel),
        .strobe (sel_strobe)
    );

    pfd_toggle u_tgl (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (sel_strobe),
        .tgl    (phase)
    );

    pfd_pin_gate u_gate (
        .tgl  (phase),
        .gate (gate),
        .pins (pins)
    );

    // Bring the pin pair out to the ports.
    always_comb begin
        pfd_p = pins.p;
        pfd_n = pins.n;
    end

    // R5: the pins are complementary while both gates are open.
    p_complement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_en && dat) |-> (pfd_p != pfd_n));

    // R6: a cleared function enable silences both pins.
    p_fn_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fn_en |-> (!pfd_p && !pfd_n));

    // R7: a cleared data bit silences both pins.
    p_dat_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dat |-> (!pfd_p && !pfd_n));

    // R2 and R3: a strobe from an unselected timer leaves the open pins unchanged.
    p_unselected_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf[src_sel] && fn_en && dat) |=>
            ((fn_en && dat && $stable(src_sel)) |-> $stable(pfd_p)));

endmodule

// File: tb/pfd_out_test.sv
// Bench for pfd_out. A behavioural model of the phase bit advances at each
// rising edge. Both pins are compared with the gated model at every
// falling edge, before the inputs are driven again.
module pfd_out_test;

    localparam int N_SRC = 2;
    localparam int WD_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ovf = 2'b00;
    logic [0:0] src_sel = 1'b0;
    logic       fn_en = 1'b0;
    logic       dat = 1'b0;
    logic       pfd_p;
    logic       pfd_n;

    int    checks = 0;
    int    errors = 0;
    int    model_phase = 0;
    string req = "R1";

    always #10 clk = ~clk;   // 50 MHz

    pfd_out #(.N_SRC(N_SRC)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf     (ovf),
        .src_sel (src_sel),
        .fn_en   (fn_en),
        .dat     (dat),
        .pfd_p   (pfd_p),
        .pfd_n   (pfd_n)
    );

    // Reference model: phase advances when the selected timer overflows.
    always @(posedge clk) begin
        if (!rst_n)
            model_phase <= 0;
        else if (ovf[src_sel] === 1'b1)
            model_phase <= 1 - model_phase;
    end

    // Compare both pins against the gated model.
    task automatic compare();
        int exp_p, exp_n;
        bit open_g;
        open_g = (fn_en === 1'b1) && (dat === 1'b1);
        exp_p = open_g ? model_phase : 0;
        exp_n = open_g ? 1 - model_phase : 0;
        checks++;
        if (pfd_p !== 1'(exp_p) || pfd_n !== 1'(exp_n)) begin
            errors++;
            $display("FAIL %s: pins p=%b n=%b expected p=%0d n=%0d at %0t",
                     req, pfd_p, pfd_n, exp_p, exp_n, $time);
        end
    endtask

    // One cycle: check the last inputs, then drive new ones.
    task automatic step(input logic [1:0] o, input logic s,
                        input logic e, input logic d);
        @(negedge clk);
        if (rst_n) compare();
        ovf = o; src_sel = s; fn_en = e; dat = d;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected end before %0d cycles", WD_CYCLES);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset, then the open pins show phase 0.
        repeat (3) @(negedge clk);
        fn_en = 1'b1; dat = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        req = "R1";
        step(2'b00, 1'b0, 1'b1, 1'b1);
        step(2'b00, 1'b0, 1'b1, 1'b1);

        // R2: timer 0 selected; overflows of timer 1 are ignored.
        req = "R2";
        step(2'b01, 1'b0, 1'b1, 1'b1);
        step(2'b00, 1'b0, 1'b1, 1'b1);
        step(2'b10, 1'b0, 1'b1, 1'b1);
        step(2'b00, 1'b0, 1'b1, 1'b1);
        step(2'b11, 1'b0, 1'b1, 1'b1);
        step(2'b00, 1'b0, 1'b1, 1'b1);

        // R8: change the select; the phase is kept.
        req = "R8";
        step(2'b00, 1'b1, 1'b1, 1'b1);
        step(2'b00, 1'b1, 1'b1, 1'b1);
        step(2'b00, 1'b0, 1'b1, 1'b1);
        step(2'b00, 1'b1, 1'b1, 1'b1);

        // R3: timer 1 selected; overflows of timer 0 are ignored.
        req = "R3";
        step(2'b01, 1'b1, 1'b1, 1'b1);
        step(2'b00, 1'b1, 1'b1, 1'b1);
        step(2'b10, 1'b1, 1'b1, 1'b1);
        step(2'b00, 1'b1, 1'b1, 1'b1);
        step(2'b11, 1'b1, 1'b1, 1'b1);
        step(2'b00, 1'b1, 1'b1, 1'b1);

        // R4 and R5: evenly spaced overflows give a divided square wave.
        req = "R4";
        for (int k = 0; k < 24; k++)
            step((k % 3 == 0) ? 2'b10 : 2'b00, 1'b1, 1'b1, 1'b1);
        req = "R5";
        for (int k = 0; k < 16; k++)
            step((k % 5 == 0) ? 2'b10 : 2'b00, 1'b1, 1'b1, 1'b1);

        // R9: a strobe held high flips the phase every cycle.
        req = "R9";
        for (int k = 0; k < 5; k++) step(2'b10, 1'b1, 1'b1, 1'b1);
        step(2'b00, 1'b1, 1'b1, 1'b1);
        step(2'b00, 1'b1, 1'b1, 1'b1);

        // R6: function disabled; pins low while the phase keeps running.
        req = "R6";
        for (int k = 0; k < 7; k++)
            step((k % 2 == 0) ? 2'b10 : 2'b00, 1'b1, 1'b0, 1'b1);
        step(2'b00, 1'b1, 1'b1, 1'b1);
        step(2'b00, 1'b1, 1'b1, 1'b1);

        // R7: data bit low; pins low, then resume with the current phase.
        req = "R7";
        for (int k = 0; k < 5; k++)
            step((k % 2 == 0) ? 2'b10 : 2'b00, 1'b1, 1'b1, 1'b0);
        step(2'b00, 1'b1, 1'b1, 1'b1);
        step(2'b00, 1'b1, 1'b1, 1'b0);
        step(2'b10, 1'b1, 1'b1, 1'b1);
        step(2'b00, 1'b1, 1'b1, 1'b1);

        // R1: reset in mid-run clears the phase again.
        req = "R1";
        step(2'b10, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        compare();
        rst_n = 1'b0;
        ovf = 2'b00;
        @(negedge clk);
        rst_n = 1'b1;
        step(2'b00, 1'b0, 1'b1, 1'b1);
        step(2'b00, 1'b0, 1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule